// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when an analog-to-digital conversion begins and when it ends. Software can launch one conversion by writing a one to the start control. It can also arm an automatic mode in which a rising edge on one of eight selectable sources launches a conversion. Source 0 is the block's own completion flag, and selecting it gives back-to-back free-running conversions.

The converter itself is modelled as a countdown of a fixed number of prescaled clock periods. When the countdown expires, the block captures a digital sample word as the result. The block presents four things: a busy indication that doubles as the readable start bit, a sticky completion flag, the channel that is currently being converted, and a one-cycle completion strobe.

The channel request can change at any time. A conversion that is already running keeps the channel that was latched when it started.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, `busy`, `done_flag` and `conv_done` are 0. `result` is all zeros, and `ch_active` is 0 while `ch_req` is 0.
- R2: A `start_wr` pulse while idle sets `busy` at the next clock edge. `busy` then stays high for exactly CONV_TICKS × 2^DIV_LOG2 cycles, because the prescaler restarts from zero at every launch.
- R3: `conv_done` is high for one cycle at the edge where `busy` falls. At that same edge `result` captures `sample_in` and `done_flag` becomes 1.
- R4: While idle, `ch_active` follows `ch_req` one cycle later. During a conversion it holds the channel latched at launch. A request made mid-conversion appears one cycle after `busy` falls.
- R5: With `auto_en` = 1 and `trig_sel` = k (1..7), a rising edge on `ext_trig[k-1]` while idle starts a conversion with the same timing as R2. Edges on the other sources have no effect.
- R6: A rising edge on the selected trigger while `busy` is high is ignored. The running conversion keeps its length, and no conversion follows it.
- R7: A trigger that is still high when a conversion completes does not start another one. A new rising edge is needed.
- R8: With `auto_en` = 0, trigger edges never start a conversion.
- R9: With `auto_en` = 1 and `trig_sel` = 0, a conversion started by `start_wr` is followed directly by the next one at every completion. `busy` stays high, and `conv_done` pulses every CONV_TICKS × 2^DIV_LOG2 cycles, whether or not `done_flag` has been cleared. Dropping `auto_en` lets the current conversion finish and then stop.
- R10: A `flag_clr_wr` pulse clears `done_flag` at the next edge. If a completion falls in the same cycle, the set wins and the flag stays 1.
- R11: A `start_wr` pulse while `busy` is high does not lengthen or repeat the running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_wr | input | 1 | Write-one pulse to the start control |
| flag_clr_wr | input | 1 | Write-one pulse that clears the completion flag |
| auto_en | input | 1 | Enables trigger-driven launches |
| trig_sel | input | SEL_W | Trigger source select; 0 is the completion flag |
| ext_trig | input | 2^SEL_W−1 | External trigger sources 1..7, at bit index k−1 |
| ch_req | input | CH_W | Requested channel |
| sample_in | input | DATA_W | Digital word captured at completion |
| busy | output | 1 | Conversion in progress / start bit readback |
| done_flag | output | 1 | Sticky completion flag |
| ch_active | output | CH_W | Channel used by the current conversion |
| conv_done | output | 1 | One-cycle completion strobe |
| result | output | DATA_W | Captured conversion result |

## Verification
The bench builds the block with DIV_LOG2 = 2 and CONV_TICKS = 13, so each conversion lasts 52 cycles. That is short enough to run three chained free-running conversions and to place a flag clear exactly on a completion edge. The channel is 3 bits wide and the data 10 bits wide, and all seven external sources are present. This makes it possible to check source selection with a wrong-source edge, triggers arriving mid-conversion, and triggers held high across a completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // Trigger source index that carries the block's own completion flag
   localparam int SELF_SRC = 0;

   // Reason for a conversion launch in the current cycle
   typedef enum logic [1:0] {
      LAUNCH_NONE,
      LAUNCH_SW,
      LAUNCH_TRIG,
      LAUNCH_CHAIN
   } launch_e;

endpackage

// File: rtl/adc_prescale.sv
module adc_prescale #(
   parameter int DIV_LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   if (DIV_LOG2 < 1 || DIV_LOG2 > 16) begin : g_bad_div
      $error("adc_prescale: DIV_LOG2 must lie in 1..16");
   end

   logic [DIV_LOG2-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   // One tick per full wrap of the divider
   assign tick = &cnt;

   // R2: a tick is never followed directly by another tick
   a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter int SEL_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<SEL_W)-1:0]   src,
   input  logic [SEL_W-1:0]        sel,
   output logic                    rise
);

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("adc_trig_edge: SEL_W must lie in 1..5");
   end

   logic cur;
   logic prev;

   assign cur = src[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= cur;
   end

   assign rise = cur & ~prev;

   // R7: a level held high yields one edge, never two in a row
   a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int CONV_TICKS = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic tick,
   output logic busy,
   output logic complete
);

   if (CONV_TICKS < 2) begin : g_bad_ticks
      $error("adc_conv_timer: CONV_TICKS must be at least 2");
   end

   localparam int CW = $clog2(CONV_TICKS);
   localparam logic [CW-1:0] LAST = CW'(CONV_TICKS - 1);

   logic [CW-1:0] cnt;

   assign complete = busy & tick & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (launch) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (complete) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy && tick) begin
         cnt  <= cnt + 1'b1;
      end
   end

   // R2: the tick count never runs past the last period
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= LAST));

   // R11: launches arrive only while idle or on the completing cycle
   a_r11_launch_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (!busy || complete));

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
   import adc_seq_pkg::*;
#(
   parameter int DATA_W     = 10,
   parameter int CH_W       = 4,
   parameter int SEL_W      = 3,
   parameter int DIV_LOG2   = 7,
   parameter int CONV_TICKS = 13
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_wr,
   input  logic                    flag_clr_wr,
   input  logic                    auto_en,
   input  logic [SEL_W-1:0]        trig_sel,
   input  logic [(1<<SEL_W)-2:0]   ext_trig,
   input  logic [CH_W-1:0]         ch_req,
   input  logic [DATA_W-1:0]       sample_in,
   output logic                    busy,
   output logic                    done_flag,
   output logic [CH_W-1:0]         ch_active,
   output logic                    conv_done,
   output logic [DATA_W-1:0]       result
);

   localparam int N_SRC = 1 << SEL_W;

   if (DATA_W < 1 || CH_W < 1) begin : g_bad_width
      $error("adc_start_seq: DATA_W and CH_W must be positive");
   end

   // ---------------- trigger source vector ----------------
   logic [N_SRC-1:0] src;
   assign src[SELF_SRC] = done_flag;
   for (genvar gi = 1; gi < N_SRC; gi++) begin : g_src
      assign src[gi] = ext_trig[gi-1];
   end

   logic tick;
   logic rise;
   logic complete;
   logic launch;
   logic free_run;
   launch_e kind;

   adc_trig_edge #(.SEL_W(SEL_W)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .sel   (trig_sel),
      .rise  (rise)
   );

   adc_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (launch),
      .tick    (tick)
   );

   adc_conv_timer #(.CONV_TICKS(CONV_TICKS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .tick     (tick),
      .busy     (busy),
      .complete (complete)
   );

   // ---------------- launch arbitration ----------------
   assign free_run = auto_en && (trig_sel == SEL_W'(SELF_SRC));

   always_comb begin
      if (complete && free_run)         kind = LAUNCH_CHAIN;
      else if (!busy && start_wr)       kind = LAUNCH_SW;
      else if (!busy && auto_en && rise) kind = LAUNCH_TRIG;
      else                              kind = LAUNCH_NONE;
   end

   assign launch = (kind != LAUNCH_NONE);

   // ---------------- flag, strobe, result, channel ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_flag <= 1'b0;
         conv_done <= 1'b0;
         result    <= '0;
         ch_active <= '0;
      end else begin
         conv_done <= complete;
         if (complete)         done_flag <= 1'b1;
         else if (flag_clr_wr) done_flag <= 1'b0;
         if (complete)         result <= sample_in;
         if (!busy || launch)  ch_active <= ch_req;
      end
   end

   // R3: the strobe always coincides with a set flag
   a_r3_strobe_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> done_flag);

   // R3: busy only drops together with the completion strobe
   a_r3_fall_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> conv_done);

   // R4: channel frozen inside a running conversion
   a_r4_channel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !conv_done) |-> $stable(ch_active));

   // R10: a clear without a coincident completion empties the flag
   a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_wr && !complete) |=> !done_flag);

   // R8: idle with auto off and no start write stays idle
   a_r8_auto_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_wr && !auto_en) |=> !busy);

   // R9: in free-running mode a completion restarts at once
   a_r9_chain_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && free_run) |=> busy);

endmodule

// File: tb/adc_start_seq_test.sv
module adc_start_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 10;
   localparam int CH_W       = 3;
   localparam int SEL_W      = 3;
   localparam int DIV_LOG2   = 2;
   localparam int CONV_TICKS = 13;
   localparam int LEN        = 52;   // 13 periods of a divide-by-4 clock

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_wr = 1'b0;
   logic flag_clr_wr = 1'b0;
   logic auto_en = 1'b0;
   logic [SEL_W-1:0] trig_sel = '0;
   logic [6:0] ext_trig = '0;
   logic [CH_W-1:0] ch_req = '0;
   logic [DATA_W-1:0] sample_in = '0;
   logic busy;
   logic done_flag;
   logic [CH_W-1:0] ch_active;
   logic conv_done;
   logic [DATA_W-1:0] result;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_start_seq #(
      .DATA_W(DATA_W), .CH_W(CH_W), .SEL_W(SEL_W),
      .DIV_LOG2(DIV_LOG2), .CONV_TICKS(CONV_TICKS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .flag_clr_wr(flag_clr_wr),
      .auto_en(auto_en), .trig_sel(trig_sel), .ext_trig(ext_trig), .ch_req(ch_req),
      .sample_in(sample_in), .busy(busy), .done_flag(done_flag), .ch_active(ch_active),
      .conv_done(conv_done), .result(result)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      start_wr = 1'b1; step(1); start_wr = 1'b0;
   endtask

   task automatic pulse_clear();
      flag_clr_wr = 1'b1; step(1); flag_clr_wr = 1'b0;
   endtask

   // Counts busy cycles from the current negedge until busy drops
   task automatic measure(output int len);
      len = 0;
      while (busy && len < 1000) begin len++; step(1); end
   endtask

   task automatic t_reset();
      check("R1 busy", int'(busy), 0);
      check("R1 done_flag", int'(done_flag), 0);
      check("R1 conv_done", int'(conv_done), 0);
      check("R1 result", int'(result), 0);
      check("R1 ch_active", int'(ch_active), 0);
   endtask

   task automatic t_single();
      int len;
      step(3);
      sample_in = 10'h2A5;
      pulse_start();
      check("R2 busy after start", int'(busy), 1);
      measure(len);
      check("R2 conversion length", len, LEN);
      check("R3 strobe at end", int'(conv_done), 1);
      check("R3 flag set", int'(done_flag), 1);
      check("R3 result captured", int'(result), 'h2A5);
      sample_in = 10'h011;
      step(1);
      check("R3 strobe one cycle", int'(conv_done), 0);
      check("R3 result held", int'(result), 'h2A5);
   endtask

   task automatic t_clear();
      pulse_clear();
      check("R10 clear", int'(done_flag), 0);
      pulse_start();
      step(51);
      check("R10 still busy before end", int'(busy), 1);
      flag_clr_wr = 1'b1; step(1); flag_clr_wr = 1'b0;
      check("R10 set wins over clear", int'(done_flag), 1);
      check("R10 conversion ended", int'(busy), 0);
      pulse_clear();
   endtask

   task automatic t_chan();
      int len;
      ch_req = 3'd3; step(2);
      check("R4 idle follow", int'(ch_active), 3);
      pulse_start();
      ch_req = 3'd5; step(10);
      check("R4 hold mid conversion", int'(ch_active), 3);
      measure(len);
      check("R4 hold at end", int'(ch_active), 3);
      step(1);
      check("R4 new channel after end", int'(ch_active), 5);
   endtask

   task automatic t_restart_ignored();
      int len;
      pulse_start();
      step(20);
      pulse_start();
      measure(len);
      check("R11 length unchanged", len, LEN - 21);
      step(10);
      check("R11 no repeat", int'(busy), 0);
   endtask

   task automatic t_trigger();
      int len;
      auto_en = 1'b1; trig_sel = 3'd3; step(3);
      ext_trig[0] = 1'b1; step(3);
      check("R5 other source ignored", int'(busy), 0);
      ext_trig[0] = 1'b0; step(1);
      ext_trig[2] = 1'b1; step(1);
      check("R5 trigger start", int'(busy), 1);
      measure(len);
      check("R5 trigger length", len, LEN);
      step(60);
      check("R7 held trigger no restart", int'(busy), 0);
      ext_trig[2] = 1'b0; step(2);
   endtask

   task automatic t_edge_busy();
      int len;
      ext_trig[2] = 1'b1; step(1);
      step(10);
      ext_trig[2] = 1'b0; step(2);
      ext_trig[2] = 1'b1; step(1);
      measure(len);
      check("R6 length unaffected", len, LEN - 13);
      ext_trig[2] = 1'b0; step(5);
      check("R6 no follow-on", int'(busy), 0);
   endtask

   task automatic t_auto_off();
      auto_en = 1'b0; step(1);
      ext_trig[2] = 1'b1; step(3);
      check("R8 auto off ignores edge", int'(busy), 0);
      ext_trig[2] = 1'b0; step(2);
   endtask

   task automatic t_free();
      int strobes = 0;
      int low = 0;
      pulse_clear();
      auto_en = 1'b1; trig_sel = 3'd0; step(5);
      check("R9 no self start", int'(busy), 0);
      pulse_start();
      for (int i = 1; i <= 156; i++) begin
         if (!busy) low++;
         if (conv_done) strobes++;
         if (i == 70) flag_clr_wr = 1'b1;
         if (i == 71) flag_clr_wr = 1'b0;
         if (i == 100) check("R9 flag cleared mid run", int'(done_flag), 0);
         step(1);
      end
      check("R9 busy never low", low, 0);
      check("R9 strobe count", strobes, 2);
      check("R9 third strobe on time", int'(conv_done), 1);
      auto_en = 1'b0;
      step(60);
      check("R9 stops after auto off", int'(busy), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      step(3);
      t_reset();
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_single();
      t_clear();
      t_chan();
      t_restart_ignored();
      t_trigger();
      t_edge_busy();
      t_auto_off();
      t_free();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule